// File: doc/BRIEF.md
# Dual-Mode Down-Counter Timer Channel

This block is one timer channel. It holds a 16-bit preset register and a 16-bit down-counter. The counter moves only on a count-enable strobe, which comes from the bus clock or from an external clock that has already been synchronized. A separate initialization strobe copies the preset into the counter. Writing the preset alone leaves the running count as it is. The channel drives a waveform output, a sticky time-out flag and the live count, which the register interface reads.

Two mode bits set how the count is treated and what the output does:

- Continuous 16-bit mode produces a square wave.
- In continuous cascaded mode, the count splits into a high byte M and a low byte L. The channel then produces a pulse train of period (M+1)(L+1).
- Single-shot mode, in either width, drives the output high from initialization until the first time-out and then holds it low. The counter itself keeps reloading and counting.

An output-enable bit masks the output and changes nothing else.

Top module: `tmr_channel`

## Requirements
- R1: After an active-low reset, the count reads 0xFFFF, the preset holds 0xFFFF, and the waveform output and the time-out flag are both 0.
- R2: A preset write does not alter the count. An initialization strobe loads the count from the preset on the next edge and takes priority over a count strobe in the same cycle.
- R3: With mode_sel_i[0]=0, each count strobe decrements the 16-bit count by one. A strobe at count 0 is a time-out and reloads the preset. With no strobe and no initialization, the count holds.
- R4: In continuous 16-bit mode (mode_sel_i=00), initialization drives the output low and every time-out toggles it, so the square wave has a period of 2(N+1) strobes.
- R5: With mode_sel_i[0]=1, high byte M and low byte L, a strobe with L at 0 and M nonzero reloads the low byte from the preset and decrements the high byte. A full time-out comes after (M+1)(L+1) strobes.
- R6: In continuous cascaded mode (mode_sel_i=01), the output is high exactly while the high byte is 0 and the low byte is nonzero. The output is therefore low for M(L+1)+1 strobes and high for L strobes of each period.
- R7: In single-shot mode (mode_sel_i[1]=1), initialization drives the output high. The first time-out drives it low, and it stays low until the next initialization while counting continues cyclically.
- R8: In single-shot mode with a zero preset, the output goes low on the first strobe after initialization, and every later strobe is a time-out.
- R9: Every time-out sets the time-out flag, in every mode, and the flag stays set until it is cleared.
- R10: A clear strobe resets the flag. A time-out in the same cycle wins, and the flag stays set.
- R11: With out_en_i=0, the waveform output is 0. The count, the flag and the internal output state evolve exactly as with out_en_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable strobe |
| init_i | input | 1 | Counter initialization strobe |
| latch_we_i | input | 1 | Preset write enable |
| latch_wdata_i | input | 16 | Preset write data |
| mode_sel_i | input | 2 | Bit 0: cascaded 8-bit halves; bit 1: single-shot |
| out_en_i | input | 1 | Waveform output enable |
| flag_clr_i | input | 1 | Time-out flag clear strobe |
| wave_o | output | 1 | Waveform output |
| timeout_o | output | 1 | Sticky time-out flag |
| count_o | output | 16 | Live count value |

## Verification
The assertions check the following on every cycle:

- preset loading on initialization;
- hold with no strobe;
- the single-step 16-bit decrement and the cascaded high-byte borrow;
- the flag set and clear priority;
- the single-shot low latch;
- output masking.

Whole-period properties span many strobes and depend on mode history, so only the bench scenarios show them. These are the 2(N+1) square wave, the split of M(L+1)+1 low strobes against L high strobes, the cyclic reload in single-shot mode and the zero-preset single-shot case.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    WM_CONT16 = 2'd0,
    WM_DUAL   = 2'd1,
    WM_SINGLE = 2'd2
  } tmr_wmode_t;
endpackage

// File: rtl/tmr_latch.sv
module tmr_latch #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '1;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W       = 16,
  parameter bit DUAL_EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         init_i,
  input  logic         dual_i,
  input  logic [W-1:0] latch_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         expire_o
);
  localparam int H = W / 2;

  logic [W-1:0] cnt_q, cnt_d, dec_val;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);

  generate
    if (DUAL_EN) begin : g_dual
      logic lo_zero;
      assign lo_zero = (cnt_q[H-1:0] == '0);
      // cascaded borrow: low half reloads, high half steps down
      always_comb begin
        if (dual_i && lo_zero) dec_val = {cnt_q[W-1:H] - 1'b1, latch_i[H-1:0]};
        else                   dec_val = cnt_q - 1'b1;
      end
    end else begin : g_flat
      assign dec_val = cnt_q - 1'b1;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (init_i)      cnt_d = latch_i;
    else if (tick_i) cnt_d = at_zero ? latch_i : dec_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '1;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
  assign expire_o  = tick_i & ~init_i & at_zero;
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  tmr_wmode_t   mode_i,
  input  logic         tick_i,
  input  logic         init_i,
  input  logic         expire_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic         out_en_i,
  output logic         wave_o
);
  localparam int H = W / 2;

  logic out_q, out_d, hi_zero, lo_live;

  assign hi_zero = (cnt_nxt_i[W-1:H] == '0);
  assign lo_live = (cnt_nxt_i[H-1:0] != '0);

  always_comb begin
    out_d = out_q;
    case (mode_i)
      WM_SINGLE: begin
        if (init_i)        out_d = 1'b1;
        else if (expire_i) out_d = 1'b0;
      end
      WM_DUAL: begin
        if (init_i || tick_i) out_d = hi_zero & lo_live;
      end
      default: begin
        if (init_i)        out_d = 1'b0;
        else if (expire_i) out_d = ~out_q;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign wave_o = out_q & out_en_i;
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             init_i,
  input  logic             latch_we_i,
  input  logic [CNT_W-1:0] latch_wdata_i,
  input  logic [1:0]       mode_sel_i,
  input  logic             out_en_i,
  input  logic             flag_clr_i,
  output logic             wave_o,
  output logic             timeout_o,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] latch_q, cnt_nxt;
  logic             expire;
  tmr_wmode_t       wmode;

  always_comb begin
    if (mode_sel_i[1])      wmode = WM_SINGLE;
    else if (mode_sel_i[0]) wmode = WM_DUAL;
    else                    wmode = WM_CONT16;
  end

  tmr_latch #(.W(CNT_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (latch_we_i),
    .wdata_i (latch_wdata_i),
    .q_o     (latch_q)
  );

  tmr_counter #(.W(CNT_W), .DUAL_EN(1'b1)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .init_i    (init_i),
    .dual_i    (mode_sel_i[0]),
    .latch_i   (latch_q),
    .cnt_o     (count_o),
    .cnt_nxt_o (cnt_nxt),
    .expire_o  (expire)
  );

  tmr_wave #(.W(CNT_W)) u_wave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (wmode),
    .tick_i    (tick_i),
    .init_i    (init_i),
    .expire_i  (expire),
    .cnt_nxt_i (cnt_nxt),
    .out_en_i  (out_en_i),
    .wave_o    (wave_o)
  );

  tmr_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (expire),
    .clr_i  (flag_clr_i),
    .flag_o (timeout_o)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         init_i,
  input logic [1:0]   mode_sel_i,
  input logic         out_en_i,
  input logic         flag_clr_i,
  input logic [W-1:0] latch_q,
  input logic [W-1:0] count_o,
  input logic         wave_o,
  input logic         timeout_o
);
  localparam int H = W / 2;

  logic expiring;
  assign expiring = tick_i && !init_i && (count_o == '0);

  assert_init_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> count_o == $past(latch_q));

  assert_count_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !tick_i) |=> $stable(count_o));

  assert_step_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !init_i && !mode_sel_i[0] && count_o != '0) |=> count_o == $past(count_o) - 1'b1);

  assert_hi_borrow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !init_i && mode_sel_i[0] && count_o[H-1:0] == '0 && count_o[W-1:H] != '0)
      |=> count_o[W-1:H] == $past(count_o[W-1:H]) - 1'b1);

  assert_single_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sel_i[1] && out_en_i && !init_i && !wave_o) |=> !wave_o);

  assert_flag_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expiring |=> timeout_o);

  assert_flag_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !expiring) |=> !timeout_o);

  assert_out_mask_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |-> !wave_o);
endmodule

bind tmr_channel tmr_channel_chk #(.W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .init_i     (init_i),
  .mode_sel_i (mode_sel_i),
  .out_en_i   (out_en_i),
  .flag_clr_i (flag_clr_i),
  .latch_q    (latch_q),
  .count_o    (count_o),
  .wave_o     (wave_o),
  .timeout_o  (timeout_o)
);

// File: tb/tmr_channel_test.sv
`timescale 1ns/1ps
module tmr_channel_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, init_i = 1'b0, latch_we_i = 1'b0;
  logic [15:0] latch_wdata_i = '0;
  logic [1:0]  mode_sel_i = 2'b00;
  logic        out_en_i = 1'b1, flag_clr_i = 1'b0;
  logic        wave_o, timeout_o;
  logic [15:0] count_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  tmr_channel uut (
    .clk_i, .rst_ni, .tick_i, .init_i, .latch_we_i, .latch_wdata_i,
    .mode_sel_i, .out_en_i, .flag_clr_i, .wave_o, .timeout_o, .count_o
  );

  // {mode[1:0], preset[15:0], strobes[7:0], exp_count[15:0], exp_wave, exp_flag}
  localparam int NV = 17;
  localparam logic [43:0] VEC [NV] = '{
    {2'd0, 16'h0005, 8'd3,  16'h0002, 1'b0, 1'b0},
    {2'd0, 16'h0005, 8'd6,  16'h0005, 1'b1, 1'b1},
    {2'd0, 16'h0003, 8'd8,  16'h0003, 1'b0, 1'b1},
    {2'd0, 16'h0003, 8'd5,  16'h0002, 1'b1, 1'b1},
    {2'd1, 16'h0203, 8'd0,  16'h0203, 1'b0, 1'b0},
    {2'd1, 16'h0203, 8'd4,  16'h0103, 1'b0, 1'b0},
    {2'd1, 16'h0203, 8'd8,  16'h0003, 1'b1, 1'b0},
    {2'd1, 16'h0203, 8'd10, 16'h0001, 1'b1, 1'b0},
    {2'd1, 16'h0203, 8'd11, 16'h0000, 1'b0, 1'b0},
    {2'd1, 16'h0203, 8'd12, 16'h0203, 1'b0, 1'b1},
    {2'd2, 16'h0004, 8'd2,  16'h0002, 1'b1, 1'b0},
    {2'd2, 16'h0004, 8'd5,  16'h0004, 1'b0, 1'b1},
    {2'd2, 16'h0004, 8'd12, 16'h0002, 1'b0, 1'b1},
    {2'd2, 16'h0000, 8'd0,  16'h0000, 1'b1, 1'b0},
    {2'd2, 16'h0000, 8'd1,  16'h0000, 1'b0, 1'b1},
    {2'd3, 16'h0101, 8'd3,  16'h0000, 1'b1, 1'b0},
    {2'd3, 16'h0101, 8'd4,  16'h0101, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, hold across one rising edge
  task automatic step(input logic t, input logic i);
    tick_i = t;
    init_i = i;
    @(negedge clk_i);
    tick_i = 1'b0;
    init_i = 1'b0;
  endtask

  task automatic write_preset(input logic [15:0] v);
    latch_we_i = 1'b1;
    latch_wdata_i = v;
    @(negedge clk_i);
    latch_we_i = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1;
    @(negedge clk_i);
    flag_clr_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(1'b1, 1'b0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 count at reset", 32'(count_o), 32'hFFFF);
    chk("R1 wave at reset", 32'(wave_o), 0);
    chk("R1 flag at reset", 32'(timeout_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(1'b0, 1'b1);
    chk("R1 preset at reset", 32'(count_o), 32'hFFFF);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  vm;
      logic [15:0] vl, vc;
      logic [7:0]  vt;
      logic        vw, vf;
      {vm, vl, vt, vc, vw, vf} = VEC[v];
      mode_sel_i = vm;
      write_preset(vl);
      clear_flag();
      step(1'b0, 1'b1);
      ticks(int'(vt));
      case (vm)
        2'd0: begin
          chk("R3 count 16-bit", 32'(count_o), 32'(vc));
          chk("R4 wave 16-bit", 32'(wave_o), 32'(vw));
        end
        2'd1: begin
          chk("R5 count cascaded", 32'(count_o), 32'(vc));
          chk("R6 wave cascaded", 32'(wave_o), 32'(vw));
        end
        default: begin
          chk("R7 count single-shot", 32'(count_o), 32'(vc));
          chk("R8 R7 wave single-shot", 32'(wave_o), 32'(vw));
        end
      endcase
      chk("R9 flag", 32'(timeout_o), 32'(vf));
    end

    // R2 preset write leaves the count alone; init beats tick
    mode_sel_i = 2'd0;
    write_preset(16'd10);
    step(1'b0, 1'b1);
    ticks(2);
    write_preset(16'd100);
    chk("R2 count after preset write", 32'(count_o), 32'd8);
    step(1'b1, 1'b1);
    chk("R2 init wins over tick", 32'(count_o), 32'd100);

    // R3 hold without strobes
    repeat (4) @(negedge clk_i);
    chk("R3 hold", 32'(count_o), 32'd100);

    // R11 output masked, counting and flag unaffected
    out_en_i = 1'b0;
    write_preset(16'd1);
    clear_flag();
    step(1'b0, 1'b1);
    ticks(2);
    chk("R11 wave masked", 32'(wave_o), 0);
    chk("R11 count unaffected", 32'(count_o), 32'd1);
    chk("R11 flag unaffected", 32'(timeout_o), 1);
    out_en_i = 1'b1;
    #1;
    chk("R11 internal state kept", 32'(wave_o), 1);
    @(negedge clk_i);

    // R10 set wins over clear, then clear alone
    write_preset(16'd0);
    clear_flag();
    step(1'b0, 1'b1);
    flag_clr_i = 1'b1;
    step(1'b1, 1'b0);
    flag_clr_i = 1'b0;
    chk("R10 set beats clear", 32'(timeout_o), 1);
    clear_flag();
    chk("R10 clear", 32'(timeout_o), 0);

    // R8 zero preset single-shot: time-out on every strobe
    mode_sel_i = 2'd2;
    step(1'b0, 1'b1);
    chk("R8 high after init", 32'(wave_o), 1);
    step(1'b1, 1'b0);
    chk("R8 low after first strobe", 32'(wave_o), 0);
    for (int k = 0; k < 3; k++) begin
      clear_flag();
      step(1'b1, 1'b0);
      chk("R8 time-out every strobe", 32'(timeout_o), 1);
      chk("R8 wave stays low", 32'(wave_o), 0);
    end

    // R7 cyclic counting while output stays low, re-armed by init
    write_preset(16'd2);
    step(1'b0, 1'b1);
    ticks(3);
    chk("R7 low after time-out", 32'(wave_o), 0);
    ticks(7);
    chk("R7 still low", 32'(wave_o), 0);
    chk("R7 cyclic count", 32'(count_o), 32'd1);
    step(1'b0, 1'b1);
    chk("R7 re-armed", 32'(wave_o), 1);

    // R4 square wave period 2(N+1), N=2
    mode_sel_i = 2'd0;
    step(1'b0, 1'b1);
    for (int k = 1; k <= 12; k++) begin
      step(1'b1, 1'b0);
      chk("R4 square wave", 32'(wave_o), 32'((k / 3) % 2));
    end

    // R6 duty in cascaded mode, M=1 L=2, over two periods
    begin
      int highs;
      highs = 0;
      mode_sel_i = 2'd1;
      write_preset(16'h0102);
      step(1'b0, 1'b1);
      for (int k = 0; k < 12; k++) begin
        step(1'b1, 1'b0);
        if (wave_o) highs++;
      end
      chk("R6 high strobes 2L", 32'(highs), 32'd4);
      chk("R6 low strobes 2(M(L+1)+1)", 32'(12 - highs), 32'd8);
      chk("R5 period (M+1)(L+1)", 32'(count_o), 32'h0102);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule